// File: doc/BRIEF.md
# Banyan Self-Routing Network

This block moves fixed-size cells from eight inputs to eight outputs through three columns of 2x2 switching elements. On each input a cell arrives as a payload with a binary output number beside it. The input stage joins the two into one word, so the output number travels as a routing header. Each column looks at one header bit, starting from the most significant. A 0 sends the cell to the upper output of its element and a 1 sends it to the lower output. The first column therefore picks the right half of the outputs, the second picks the right quarter, and the last picks the port itself. The columns are joined by a perfect shuffle. Each column drops the header bit it has just used, so the cell that leaves the last column is the bare payload.

Every element has a registered output, so a cell leaves the network three clock cycles after it enters. A new set of cells can be offered on every cycle. There are no buffers inside the elements and no sorting stage in front of the network. When both inputs of one element want the same output in the same cycle, the element keeps the cell on its upper input and discards the other. The element raises a per-column collision pulse, and a running total of discarded cells is kept.

Each element makes one routing decision per cycle, and that decision is one of four named states. IDLE means no input is valid. BAR passes upper to upper and lower to lower. CROSS swaps the two. CLASH means both inputs request the same side: the upper cell takes that side and the lower cell is discarded. A cycle's state depends only on the valid flags and header bits seen in that cycle, so any state can follow any other. Every transition is possible and none is held over from the previous cycle.

Top module: `banyan_net`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is all zero, `coll_stage` is zero and `coll_count` is zero.
- R2: A cell offered alone on any input with destination `d` appears on output `d` exactly 3 cycles later, with its payload unchanged and no header bits attached. No other output is valid in that cycle.
- R3: Before each column, the cell on line `p` moves to line `((p<<1)|(p>>2)) mod 8`. Element `j` of a column takes lines `2j` (its upper input) and `2j+1` (its lower input), and drives lines `2j` (upper output) and `2j+1` (lower output). Column `k` (k = 0, 1, 2) routes on destination bit `2-k`: 0 goes to the upper output and 1 to the lower output.
- R4: `coll_stage[k]` is high for exactly those cycles in which at least one element of column `k` received two valid cells with equal routing bits. This is the cycle in which the surviving cells of that column are presented, k+1 cycles after the cells entered the network.
- R5: In a collision, the cell on the upper input continues on its requested side and the lower-input cell is discarded. A discarded cell never appears on any output.
- R6: `coll_count` rises by the number of collisions across all elements and columns. It rises one cycle after the corresponding `coll_stage` pulses.
- R7: A fully loaded cycle in which input `p` is sent to `(p+s) mod 8`, for any shift `s`, is delivered to all eight outputs with no collision.
- R8: Cells offered on consecutive cycles do not interfere with one another across cycles. Each cycle's set of cells is routed as if it were alone in the network.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Per-input cell present flag |
| in_data | input | 64 | Payloads, input p in bits [8p+7:8p] |
| in_dest | input | 24 | Destination port numbers, input p in bits [3p+2:3p] |
| out_valid | output | 8 | Per-output cell present flag |
| out_data | output | 64 | Delivered payloads, output p in bits [8p+7:8p] |
| coll_stage | output | 3 | Collision pulse, bit k for column k |
| coll_count | output | 16 | Running total of discarded cells |

## Verification
The bench drives two cells into the same first-column element with equal leading bits. If the tie went the wrong way, the lower input's payload would reach the destination. If the loser were not discarded, the loser would show up as a second valid output. The bench also runs every source-to-destination pair one cell at a time and every cyclic shift at full load. A wrong shuffle or a reversed bit order would deliver cells to the wrong port, and it would also raise false collisions on the shift patterns. A stream of random back-to-back cycles checks the column pulses and the total against a behavioural model. A pulse tied to the wrong column, or a counter that counts pulses instead of collisions, shows up there as a timing or value mismatch.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_BAR,
        SW_CROSS,
        SW_CLASH
    } sw_route_e;

    function automatic int unsigned shuffle_pos(input int unsigned p, input int unsigned bits);
        int unsigned mask;
        mask = (32'd1 << bits) - 32'd1;
        return ((p << 1) | (p >> (bits - 1))) & mask;
    endfunction

    function automatic int unsigned chain_off(input int unsigned s, input int unsigned n,
                                              input int unsigned w, input int unsigned lg);
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < s; i++) begin
            acc += n * (w + lg - i);
        end
        return acc;
    endfunction

endpackage

// File: rtl/banyan_hdr_attach.sv
module banyan_hdr_attach #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int LG = 3
) (
    input  logic [N*W-1:0]      pay_in,
    input  logic [N*LG-1:0]     dest_in,
    output logic [N*(W+LG)-1:0] cell_out
);
    localparam int CW = W + LG;

    for (genvar p = 0; p < N; p++) begin : g_port
        assign cell_out[p*CW +: CW] = {dest_in[p*LG +: LG], pay_in[p*W +: W]};
    end

endmodule

// File: rtl/banyan_element.sv
module banyan_element #(
    parameter int CWI = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           up_v,
    input  logic [CWI-1:0] up_c,
    input  logic           lo_v,
    input  logic [CWI-1:0] lo_c,
    output logic           oup_v,
    output logic [CWI-2:0] oup_c,
    output logic           olo_v,
    output logic [CWI-2:0] olo_c,
    output logic           clash
);
    import banyan_pkg::*;

    localparam int CWO = CWI - 1;

    sw_route_e      route;
    logic           up_b;
    logic           lo_b;
    logic [CWO-1:0] up_t;
    logic [CWO-1:0] lo_t;
    logic           nx_uv;
    logic           nx_lv;
    logic [CWO-1:0] nx_uc;
    logic [CWO-1:0] nx_lc;

    assign up_b = up_c[CWI-1];
    assign lo_b = lo_c[CWI-1];
    assign up_t = up_c[CWO-1:0];
    assign lo_t = lo_c[CWO-1:0];

    // routing decision for this cycle
    always_comb begin
        if (!up_v && !lo_v) begin
            route = SW_IDLE;
        end else if (up_v && lo_v && (up_b == lo_b)) begin
            route = SW_CLASH;
        end else if (up_v ? !up_b : lo_b) begin
            route = SW_BAR;
        end else begin
            route = SW_CROSS;
        end
    end

    // next outputs per decision
    always_comb begin
        nx_uv = 1'b0;
        nx_lv = 1'b0;
        nx_uc = '0;
        nx_lc = '0;
        unique case (route)
            SW_IDLE: begin
            end
            SW_BAR: begin
                nx_uv = up_v;
                nx_uc = up_t;
                nx_lv = lo_v;
                nx_lc = lo_t;
            end
            SW_CROSS: begin
                nx_uv = lo_v;
                nx_uc = lo_t;
                nx_lv = up_v;
                nx_lc = up_t;
            end
            SW_CLASH: begin
                if (up_b) begin
                    nx_lv = 1'b1;
                    nx_lc = up_t;
                end else begin
                    nx_uv = 1'b1;
                    nx_uc = up_t;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oup_v <= 1'b0;
            olo_v <= 1'b0;
            oup_c <= '0;
            olo_c <= '0;
            clash <= 1'b0;
        end else begin
            oup_v <= nx_uv;
            olo_v <= nx_lv;
            oup_c <= nx_uc;
            olo_c <= nx_lc;
            clash <= (route == SW_CLASH);
        end
    end

endmodule

// File: rtl/banyan_stage.sv
module banyan_stage #(
    parameter int N   = 8,
    parameter int CWI = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       in_v,
    input  logic [N*CWI-1:0]   in_c,
    output logic [N-1:0]       out_v,
    output logic [N*(CWI-1)-1:0] out_c,
    output logic [N/2-1:0]     clash
);
    import banyan_pkg::*;

    localparam int LG  = $clog2(N);
    localparam int CWO = CWI - 1;

    logic [N-1:0]     sh_v;
    logic [N*CWI-1:0] sh_c;

    // perfect shuffle ahead of the column
    for (genvar p = 0; p < N; p++) begin : g_shuf
        localparam int unsigned Q = shuffle_pos(p, LG);
        assign sh_v[Q]            = in_v[p];
        assign sh_c[Q*CWI +: CWI] = in_c[p*CWI +: CWI];
    end

    for (genvar j = 0; j < N/2; j++) begin : g_elem
        banyan_element #(
            .CWI(CWI)
        ) u_elem (
            .clk   (clk),
            .rst_n (rst_n),
            .up_v  (sh_v[2*j]),
            .up_c  (sh_c[(2*j)*CWI +: CWI]),
            .lo_v  (sh_v[2*j+1]),
            .lo_c  (sh_c[(2*j+1)*CWI +: CWI]),
            .oup_v (out_v[2*j]),
            .oup_c (out_c[(2*j)*CWO +: CWO]),
            .olo_v (out_v[2*j+1]),
            .olo_c (out_c[(2*j+1)*CWO +: CWO]),
            .clash (clash[j])
        );
    end

endmodule

// File: rtl/banyan_net.sv
module banyan_net #(
    parameter int N     = 8,
    parameter int W     = 8,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           in_valid,
    input  logic [N*W-1:0]         in_data,
    input  logic [N*$clog2(N)-1:0] in_dest,
    output logic [N-1:0]           out_valid,
    output logic [N*W-1:0]         out_data,
    output logic [$clog2(N)-1:0]   coll_stage,
    output logic [CNT_W-1:0]       coll_count
);
    import banyan_pkg::*;

    localparam int LG     = $clog2(N);
    localparam int HALF   = N / 2;
    localparam int NCLASH = LG * HALF;
    localparam int HITW   = $clog2(NCLASH + 1);
    localparam int CHAINW = chain_off(LG + 1, N, W, LG);

    logic [N-1:0]      v_chain [LG+1];
    logic [CHAINW-1:0] c_chain;
    logic [NCLASH-1:0] clash_all;
    logic [HITW-1:0]   hits;
    logic [CNT_W-1:0]  cnt_q;

    banyan_hdr_attach #(
        .N  (N),
        .W  (W),
        .LG (LG)
    ) u_attach (
        .pay_in   (in_data),
        .dest_in  (in_dest),
        .cell_out (c_chain[0 +: N*(W+LG)])
    );

    assign v_chain[0] = in_valid;

    for (genvar s = 0; s < LG; s++) begin : g_col
        localparam int CWI  = W + LG - s;
        localparam int OFFI = chain_off(s, N, W, LG);
        localparam int OFFO = chain_off(s + 1, N, W, LG);

        banyan_stage #(
            .N   (N),
            .CWI (CWI)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .in_v  (v_chain[s]),
            .in_c  (c_chain[OFFI +: N*CWI]),
            .out_v (v_chain[s+1]),
            .out_c (c_chain[OFFO +: N*(CWI-1)]),
            .clash (clash_all[s*HALF +: HALF])
        );

        assign coll_stage[s] = |clash_all[s*HALF +: HALF];
    end

    always_comb begin
        hits = '0;
        for (int i = 0; i < NCLASH; i++) begin
            hits = hits + HITW'(clash_all[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(hits);
        end
    end

    assign out_valid  = v_chain[LG];
    assign out_data   = c_chain[chain_off(LG, N, W, LG) +: N*W];
    assign coll_count = cnt_q;

endmodule

// File: rtl/banyan_net_chk.sv
module banyan_net_chk #(
    parameter int N     = 8,
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         in_valid,
    input logic [N-1:0]         out_valid,
    input logic [$clog2(N)-1:0] coll_stage,
    input logic [CNT_W-1:0]     coll_count
);
    localparam int LG = $clog2(N);

    logic [7:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= '0;
        end else if (since < 8'(LG)) begin
            since <= since + 8'd1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0 && coll_stage == '0 && coll_count == '0)); // R1

    AST_NO_CELL_CREATED: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 8'(LG)) |-> ($countones(out_valid) <= $countones($past(in_valid, LG)))); // R5

    AST_PULSE_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 8'd1 && coll_stage[0]) |-> ($countones($past(in_valid)) >= 2)); // R4

    AST_COUNT_FOLLOWS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|coll_stage) |=> (coll_count != $past(coll_count))); // R6

    AST_COUNT_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 8'd1 && coll_count != $past(coll_count)) |-> $past(|coll_stage)); // R6

endmodule

bind banyan_net banyan_net_chk #(
    .N     (N),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .coll_stage (coll_stage),
    .coll_count (coll_count)
);

// File: tb/banyan_net_tb.sv
module banyan_net_tb;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int LG = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  in_valid = '0;
    logic [N*W-1:0]  in_data = '0;
    logic [N*LG-1:0] in_dest = '0;
    logic [N-1:0]  out_valid;
    logic [N*W-1:0]  out_data;
    logic [LG-1:0] coll_stage;
    logic [15:0]   coll_count;

    always #5 clk = ~clk;

    banyan_net u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_dest    (in_dest),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .coll_stage (coll_stage),
        .coll_count (coll_count)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_cnt = 0;

    int st_v[8];
    int st_h[8];
    int st_d[8];

    int e_ov[8][8];
    int e_od[8][8];
    int e_cs[8];
    int e_cd[8];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: route one cycle's cells through all columns
    task automatic model_inject(input int c);
        int v[8], h[8], d[8];
        int sv[8], sh[8], sd[8];
        int nv[8], nh[8], nd[8];
        for (int p = 0; p < 8; p++) begin
            v[p] = st_v[p];
            h[p] = st_h[p];
            d[p] = st_d[p];
        end
        for (int k = 0; k < 3; k++) begin
            int cnt;
            cnt = 0;
            for (int p = 0; p < 8; p++) begin
                int q;
                q = ((p << 1) | (p >> 2)) & 7;
                sv[q] = v[p];
                sh[q] = h[p];
                sd[q] = d[p];
            end
            for (int p = 0; p < 8; p++) begin
                nv[p] = 0;
                nh[p] = 0;
                nd[p] = 0;
            end
            for (int j = 0; j < 4; j++) begin
                int u, l, bu, bl;
                u  = 2 * j;
                l  = 2 * j + 1;
                bu = (sh[u] >> (2 - k)) & 1;
                bl = (sh[l] >> (2 - k)) & 1;
                if (sv[u] != 0 && sv[l] != 0 && bu == bl) begin
                    cnt++;
                    nv[2*j+bu] = 1;
                    nh[2*j+bu] = sh[u];
                    nd[2*j+bu] = sd[u];
                end else begin
                    if (sv[u] != 0) begin
                        nv[2*j+bu] = 1;
                        nh[2*j+bu] = sh[u];
                        nd[2*j+bu] = sd[u];
                    end
                    if (sv[l] != 0) begin
                        nv[2*j+bl] = 1;
                        nh[2*j+bl] = sh[l];
                        nd[2*j+bl] = sd[l];
                    end
                end
            end
            for (int p = 0; p < 8; p++) begin
                v[p] = nv[p];
                h[p] = nh[p];
                d[p] = nd[p];
            end
            if (cnt > 0) e_cs[(c + 1 + k) % 8] |= (1 << k);
            e_cd[(c + 2 + k) % 8] += cnt;
        end
        for (int p = 0; p < 8; p++) begin
            e_ov[(c + 3) % 8][p] = v[p];
            e_od[(c + 3) % 8][p] = d[p];
        end
    endtask

    task automatic compare_slot();
        int s;
        s = cyc % 8;
        for (int p = 0; p < 8; p++) begin
            chk(int'(out_valid[p]) == e_ov[s][p], "R2/R3/R5 out_valid", int'(out_valid[p]), e_ov[s][p]);
            if (e_ov[s][p] != 0 && out_valid[p]) begin
                chk(int'(out_data[p*W +: W]) == e_od[s][p], "R2/R8 out_data",
                    int'(out_data[p*W +: W]), e_od[s][p]);
            end
        end
        chk(int'(coll_stage) == e_cs[s], "R4 coll_stage", int'(coll_stage), e_cs[s]);
        exp_cnt += e_cd[s];
        chk(int'(coll_count) == exp_cnt, "R6 coll_count", int'(coll_count), exp_cnt);
        for (int p = 0; p < 8; p++) begin
            e_ov[s][p] = 0;
            e_od[s][p] = 0;
        end
        e_cs[s] = 0;
        e_cd[s] = 0;
    endtask

    // drive st_* for one cycle, advance one clock and compare
    task automatic step();
        for (int p = 0; p < 8; p++) begin
            in_valid[p]        = (st_v[p] != 0);
            in_data[p*W +: W]  = W'(st_d[p]);
            in_dest[p*LG +: LG] = LG'(st_h[p]);
        end
        model_inject(cyc);
        @(posedge clk);
        cyc++;
        @(negedge clk);
        compare_slot();
    endtask

    task automatic clear_stim();
        for (int p = 0; p < 8; p++) begin
            st_v[p] = 0;
            st_h[p] = 0;
            st_d[p] = 0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        for (int s = 0; s < 8; s++) begin
            e_cs[s] = 0;
            e_cd[s] = 0;
            for (int p = 0; p < 8; p++) begin
                e_ov[s][p] = 0;
                e_od[s][p] = 0;
            end
        end
        clear_stim();

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(coll_stage == '0, "R1 coll_stage in reset", int'(coll_stage), 0);
        chk(coll_count == '0, "R1 coll_count in reset", int'(coll_count), 0);
        rst_n = 1'b1;
        step();
        chk(out_valid == '0 && coll_count == '0, "R1 first cycle after reset",
            int'(out_valid), 0);

        // R2, R8: every source/destination pair, one cell per cycle, back to back
        for (int src = 0; src < 8; src++) begin
            for (int dst = 0; dst < 8; dst++) begin
                clear_stim();
                st_v[src] = 1;
                st_h[src] = dst;
                st_d[src] = ((src << 3) | dst) ^ 8'hA5;
                step();
            end
        end
        clear_stim();
        repeat (4) step();

        // R2: explicit latency check for one lone cell
        st_v[6] = 1; st_h[6] = 2; st_d[6] = 8'h3C;
        step();
        clear_stim();
        step();
        step();
        chk(out_valid == 8'b0000_0100, "R2 lone cell arrives 3 cycles later",
            int'(out_valid), 4);
        chk(out_data[2*W +: W] == 8'h3C, "R2 payload intact", int'(out_data[2*W +: W]), 8'h3C);
        step();

        // R7: cyclic shifts at full load are conflict free
        base = exp_cnt;
        for (int sft = 0; sft < 8; sft++) begin
            for (int p = 0; p < 8; p++) begin
                st_v[p] = 1;
                st_h[p] = (p + sft) % 8;
                st_d[p] = (sft << 4) | p;
            end
            step();
        end
        clear_stim();
        repeat (4) step();
        chk(int'(coll_count) == base, "R7 no collisions for shift patterns",
            int'(coll_count), base);

        // R5: inputs 0 and 4 share a first-column element, both toward port 5
        st_v[0] = 1; st_h[0] = 5; st_d[0] = 8'h11;
        st_v[4] = 1; st_h[4] = 5; st_d[4] = 8'h44;
        step();
        clear_stim();
        chk(coll_stage == 3'b001, "R4 column 0 pulse", int'(coll_stage), 1);
        step();
        step();
        chk(out_valid == 8'b0010_0000, "R5 only winner delivered", int'(out_valid), 32);
        chk(out_data[5*W +: W] == 8'h11, "R5 upper input wins", int'(out_data[5*W +: W]), 8'h11);
        step();

        // R4, R5, R6: every input aimed at port 0
        for (int p = 0; p < 8; p++) begin
            st_v[p] = 1;
            st_h[p] = 0;
            st_d[p] = 8'h80 | p;
        end
        step();
        clear_stim();
        repeat (5) step();

        // R3, R4, R6, R8: random traffic, back to back
        for (int n = 0; n < 300; n++) begin
            for (int p = 0; p < 8; p++) begin
                st_v[p] = (($urandom % 4) != 0) ? 1 : 0;
                st_h[p] = int'($urandom % 8);
                st_d[p] = int'($urandom % 256);
            end
            step();
        end
        clear_stim();
        repeat (6) step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule